// File: doc/BRIEF.md
# Dual-Rate External Interface Clock Generator

This block derives the clock for an external parallel interface from the system clock. A 32-bit divider word carries two 16-bit divider fields, one for each of two chip selects. A dual-rate enable chooses between two cases. When it is set, the chip-select input picks which field sets the rate. When it is clear, the low field sets the rate for both chip selects. The clock can also be gated, so that it stops while no transfer is pending.

A nonzero divider value D gives an interface period of 2*(floor(D/2)+1) system clocks. Odd values therefore round up to the next even division. The output is high for the first half of each period and low for the second half. A divider value of zero selects bypass: the interface runs at the system clock rate. In bypass the clock output stays high and both edge strobes fire on every cycle. Transaction logic in the same clock domain uses the registered rising-edge and falling-edge strobes as clock enables. New divider, chip-select and gating values are sampled only at period boundaries, so no phase is ever cut short.

Top module: `xbc_clkgen`

## Requirements
- R1: While reset is asserted, `ifclk_out`, `rise_stb` and `fall_stb` are all 0.
- R2: If the selected divider is 0, every cycle is one full period. `ifclk_out` is 1, and `rise_stb` and `fall_stb` are both 1 in every cycle.
- R3: A nonzero selected divider D makes `ifclk_out` high for floor(D/2)+1 cycles and then low for floor(D/2)+1 cycles. So D=1 gives a period of 2, D=2 and D=3 give 4, and D=4 gives 6.
- R4: Outside bypass, `rise_stb` is 1 only in the first high cycle of a period and `fall_stb` is 1 only in the first low cycle.
- R5: With `dual_rate_en`=1, `cs_sel`=0 selects `div_word[15:0]` and `cs_sel`=1 selects `div_word[31:16]`.
- R6: With `dual_rate_en`=0, `div_word[15:0]` is used whatever the value of `cs_sel`, and `div_word[31:16]` has no effect on the output.
- R7: Changes to `div_word`, `dual_rate_en` or `cs_sel` take effect only at a period boundary. A period that has already started completes at its old length.
- R8: While `gate_en`=1 and `xfer_pending`=0, no new period starts. After the current period ends, `ifclk_out` stays 0 with no strobes.
- R9: When a pending transfer appears while the clock is stopped, the next cycle is the first high cycle of a new period, with `rise_stb`=1.
- R10: With `gate_en`=0 the clock runs freely, whatever the value of `xfer_pending`.
- R11: The largest field value, 65535, gives high and low phases of 32768 cycles each.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_word | input | 32 | Divider word: [15:0] for chip select 0, [31:16] for chip select 1 |
| dual_rate_en | input | 1 | 1: each chip select uses its own field; 0: the low field is used for both |
| cs_sel | input | 1 | Active chip select (0 or 1) |
| gate_en | input | 1 | 1: stop the clock when no transfer is pending |
| xfer_pending | input | 1 | A transfer is waiting for the interface clock |
| ifclk_out | output | 1 | Divided interface clock (registered) |
| rise_stb | output | 1 | First cycle of the high phase |
| fall_stb | output | 1 | First cycle of the low phase |

## Verification
A wrong half-period limit or counter shows up within one interface period, as unequal high and low phase lengths or as a period length that does not match the selected field. A wrong field selection or a missed bypass decode shows up at the first period boundary after the inputs change. A boundary detected too early shows up as a shortened phase in the period that is already under way. A gating fault shows up as a strobe while the clock should be stopped, or as a missing rising strobe in the cycle after a transfer becomes pending.

// File: rtl/xbc_pkg.sv
package xbc_pkg;

  // Width of one divider field; the divider word carries one field per chip select.
  localparam int unsigned XBC_DIV_W    = 16;
  localparam int unsigned XBC_CS_COUNT = 2;

  // Phase sequencer states.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2,
    PH_BYP  = 2'd3
  } xbc_phase_e;

endpackage

// File: rtl/xbc_div_select.sv
module xbc_div_select
  import xbc_pkg::*;
#(
  parameter int unsigned DIV_W    = XBC_DIV_W,
  parameter int unsigned CS_COUNT = XBC_CS_COUNT,
  localparam int unsigned CS_W    = (CS_COUNT > 1) ? $clog2(CS_COUNT) : 1,
  localparam int unsigned WORD_W  = DIV_W * CS_COUNT
) (
  input  logic [WORD_W-1:0] div_word,
  input  logic              dual_rate_en,
  input  logic [CS_W-1:0]   cs_sel,
  output logic [DIV_W-1:0]  div_eff
);

  logic [DIV_W-1:0] field [CS_COUNT];

  // Slice the divider word into one field per chip select.
  for (genvar g = 0; g < CS_COUNT; g++) begin : g_field
    assign field[g] = div_word[g*DIV_W +: DIV_W];
  end

  logic [CS_W-1:0] pick;

  always_comb begin
    pick = '0;
    if (dual_rate_en && (int'(cs_sel) < CS_COUNT)) begin
      pick = cs_sel;
    end
    div_eff = field[pick];
  end

endmodule

// File: rtl/xbc_phase_gen.sv
module xbc_phase_gen
  import xbc_pkg::*;
#(
  parameter int unsigned DIV_W = XBC_DIV_W,
  localparam int unsigned CNT_W = DIV_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_eff,
  input  logic             run_req,
  output logic             ifclk_o,
  output logic             rise_o,
  output logic             fall_o
);

  xbc_phase_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic             ifclk_q, ifclk_d;
  logic             rise_q, rise_d;
  logic             fall_q, fall_d;
  logic             lim_en;
  logic             at_lim;
  logic             boundary;

  // Next-state logic.
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    lim_d    = lim_q;
    rise_d   = 1'b0;
    fall_d   = 1'b0;
    lim_en   = 1'b0;
    at_lim   = (cnt_q == lim_q);
    boundary = (state_q == PH_IDLE) || (state_q == PH_BYP) ||
               ((state_q == PH_LOW) && at_lim);

    if (boundary) begin
      cnt_d = '0;
      if (!run_req) begin
        state_d = PH_IDLE;
      end else if (div_eff == '0) begin
        state_d = PH_BYP;
        rise_d  = 1'b1;
        fall_d  = 1'b1;
      end else begin
        state_d = PH_HIGH;
        lim_en  = 1'b1;
        lim_d   = div_eff[DIV_W-1:1];
        rise_d  = 1'b1;
      end
    end else if ((state_q == PH_HIGH) && at_lim) begin
      state_d = PH_LOW;
      cnt_d   = '0;
      fall_d  = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end

    ifclk_d = (state_d == PH_HIGH) || (state_d == PH_BYP);
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      ifclk_q <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ifclk_q <= ifclk_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
    end
  end

  // Half-period limit, loaded only when a divided period starts.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '0;
    end else if (lim_en) begin
      lim_q <= lim_d;
    end
  end

  assign ifclk_o = ifclk_q;
  assign rise_o  = rise_q;
  assign fall_o  = fall_q;

endmodule

// File: rtl/xbc_clkgen.sv
module xbc_clkgen
  import xbc_pkg::*;
#(
  parameter int unsigned DIV_W = XBC_DIV_W,
  localparam int unsigned WORD_W = 2 * DIV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] div_word,
  input  logic              dual_rate_en,
  input  logic              cs_sel,
  input  logic              gate_en,
  input  logic              xfer_pending,
  output logic              ifclk_out,
  output logic              rise_stb,
  output logic              fall_stb
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [DIV_W-1:0] div_eff;
  logic             run_req;

  assign run_req = !gate_en || xfer_pending;

  xbc_div_select #(
    .DIV_W    (DIV_W),
    .CS_COUNT (2)
  ) u_sel (
    .div_word     (div_word),
    .dual_rate_en (dual_rate_en),
    .cs_sel       (cs_sel),
    .div_eff      (div_eff)
  );

  xbc_phase_gen #(
    .DIV_W (DIV_W)
  ) u_phase (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .div_eff (div_eff),
    .run_req (run_req),
    .ifclk_o (ifclk_out),
    .rise_o  (rise_stb),
    .fall_o  (fall_stb)
  );

endmodule

// File: rtl/xbc_checker.sv
module xbc_checker
  import xbc_pkg::*;
#(
  parameter int unsigned DIV_W = XBC_DIV_W,
  localparam int unsigned WORD_W = 2 * DIV_W,
  localparam int unsigned LEN_W  = DIV_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] div_word,
  input logic              dual_rate_en,
  input logic              cs_sel,
  input logic              gate_en,
  input logic              xfer_pending,
  input logic              ifclk_out,
  input logic              rise_stb,
  input logic              fall_stb
);

  // Phase length bookkeeping for the equal-halves check.
  logic [LEN_W-1:0] run_len;
  logic [LEN_W-1:0] hi_len;
  logic             low_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
      hi_len  <= '0;
      low_ok  <= 1'b0;
    end else begin
      if (rise_stb || fall_stb) begin
        run_len <= LEN_W'(1);
      end else begin
        run_len <= run_len + 1'b1;
      end
      if (fall_stb && !rise_stb) begin
        hi_len <= run_len;
      end
      if (gate_en && !xfer_pending) begin
        low_ok <= 1'b0;
      end else if (rise_stb) begin
        low_ok <= 1'b0;
      end else if (fall_stb) begin
        low_ok <= 1'b1;
      end
    end
  end

  // R3: the low phase lasts as long as the high phase before it.
  assert_equal_halves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_stb && !fall_stb && low_ok) |-> (run_len == hi_len));

  // R4: the rising strobe marks a high output.
  assert_rise_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> ifclk_out);

  // R4: every rising output edge carries the rising strobe.
  assert_rose_marked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ifclk_out) |-> rise_stb);

  // R4: every falling output edge carries the falling strobe.
  assert_fell_marked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ifclk_out) |-> fall_stb);

  // R4: a lone falling strobe marks a low output.
  assert_fall_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_stb && !rise_stb) |-> !ifclk_out);

  // R2: both strobes together only in bypass, with the output high.
  assert_bypass_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_stb && fall_stb) |-> ifclk_out);

  // R8: no new period begins while gated without a pending transfer.
  assert_gate_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !xfer_pending) |=> !rise_stb);

endmodule

bind xbc_clkgen xbc_checker #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/sim_xbc_clkgen.sv
`timescale 1ns/1ps
module sim_xbc_clkgen;

  logic        clk;
  logic        rst_n;
  logic [31:0] div_word;
  logic        dual_rate_en;
  logic        cs_sel;
  logic        gate_en;
  logic        xfer_pending;
  logic        ifclk_out;
  logic        rise_stb;
  logic        fall_stb;

  int n_chk;
  int n_bad;
  int cur_eff;

  xbc_clkgen u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .div_word     (div_word),
    .dual_rate_en (dual_rate_en),
    .cs_sel       (cs_sel),
    .gate_en      (gate_en),
    .xfer_pending (xfer_pending),
    .ifclk_out    (ifclk_out),
    .rise_stb     (rise_stb),
    .fall_stb     (fall_stb)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int exp_eff(input logic [31:0] w, input logic d, input logic c);
    if (d && c) return int'(w[31:16]);
    return int'(w[15:0]);
  endfunction

  function automatic int exp_half(input int d);
    return d / 2 + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a sample showing the first cycle of a period; returns at the next period start.
  task automatic measure(input int eff, input string tag);
    int half;
    int hi;
    int lo;
    bit sok;
    if (eff == 0) begin
      chk(rise_stb && fall_stb && ifclk_out, {tag, " R2 bypass"},
          {ifclk_out, rise_stb, fall_stb}, 3'b111);
      @(negedge clk);
      return;
    end
    half = exp_half(eff);
    hi   = 1;
    lo   = 0;
    sok  = rise_stb && ifclk_out && !fall_stb;
    @(negedge clk);
    while (ifclk_out && hi < 70000) begin
      if (rise_stb || fall_stb) sok = 1'b0;
      hi++;
      @(negedge clk);
    end
    if (!fall_stb) sok = 1'b0;
    lo = 1;
    @(negedge clk);
    while (!ifclk_out && lo < 70000) begin
      if (rise_stb || fall_stb) sok = 1'b0;
      lo++;
      @(negedge clk);
    end
    if (!rise_stb) sok = 1'b0;
    chk(hi == half, {tag, " R3 high length"}, hi, half);
    chk(lo == half, {tag, " R3 low length"}, lo, half);
    chk(sok, {tag, " R4 strobe placement"}, sok, 1);
  endtask

  // Apply new settings mid-period: old period finishes (R7), then new one runs.
  task automatic step(input logic [31:0] w, input logic d, input logic c, input string tag);
    int nxt;
    nxt = exp_eff(w, d, c);
    div_word     = w;
    dual_rate_en = d;
    cs_sel       = c;
    measure(cur_eff, "R7 old period");
    measure(nxt, tag);
    cur_eff = nxt;
  endtask

  task automatic wait_rise();
    int guard;
    guard = 0;
    while (!rise_stb && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    void'($urandom(32'd2718));
    rst_n        = 1'b0;
    div_word     = {16'd0, 16'd2};
    dual_rate_en = 1'b0;
    cs_sel       = 1'b0;
    gate_en      = 1'b0;
    xfer_pending = 1'b0;
    repeat (4) @(negedge clk);
    // R1: outputs quiet in reset
    chk(!ifclk_out && !rise_stb && !fall_stb, "R1 reset state",
        {ifclk_out, rise_stb, fall_stb}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    wait_rise();
    cur_eff = 2;
    measure(2, "R3 D=2");

    step({16'd9, 16'd1}, 1'b0, 1'b0, "R3 D=1");
    step({16'd9, 16'd3}, 1'b0, 1'b0, "R3 D=3 odd");
    step({16'd9, 16'd4}, 1'b0, 1'b0, "R3 D=4");
    step({16'd9, 16'd0}, 1'b0, 1'b0, "R2 D=0");
    measure(0, "R2 repeat");
    measure(0, "R2 repeat");
    step({16'd5, 16'd1}, 1'b1, 1'b1, "R5 cs1 upper");
    step({16'd5, 16'd1}, 1'b1, 1'b0, "R5 cs0 lower");
    step({16'd5, 16'd1}, 1'b0, 1'b1, "R6 dual off ignores upper");
    step({16'd0, 16'd1}, 1'b1, 1'b1, "R5 cs1 bypass");
    step({16'd6, 16'd4}, 1'b0, 1'b0, "R3 D=4 again");

    // R10: gated but pending keeps running
    gate_en      = 1'b1;
    xfer_pending = 1'b1;
    measure(4, "R10 gated pending");
    // R8: gated with nothing pending stops after current period
    xfer_pending = 1'b0;
    repeat (10) @(negedge clk);
    begin
      bit quiet;
      quiet = 1'b1;
      for (int i = 0; i < 8; i++) begin
        if (ifclk_out || rise_stb || fall_stb) quiet = 1'b0;
        @(negedge clk);
      end
      chk(quiet, "R8 stopped clock quiet", quiet, 1);
    end
    // R9: restart one cycle after pending
    xfer_pending = 1'b1;
    @(negedge clk);
    chk(rise_stb && ifclk_out, "R9 restart strobe", {ifclk_out, rise_stb}, 2'b11);
    measure(4, "R9 restarted period");
    gate_en      = 1'b0;
    xfer_pending = 1'b0;
    measure(4, "R10 free running");

    // Constrained random settings
    for (int k = 0; k < 30; k++) begin
      logic [31:0] w;
      logic        d;
      logic        c;
      w = {10'd0, 6'($urandom()), 10'd0, 6'($urandom())};
      if (($urandom() % 6) == 0) w[15:0] = 16'd0;
      d = 1'($urandom());
      c = 1'($urandom());
      gate_en      = 1'($urandom());
      xfer_pending = gate_en;
      step(w, d, c, "R5 R6 random");
    end

    // R11: largest field value
    gate_en      = 1'b0;
    xfer_pending = 1'b0;
    step({16'd1, 16'hFFFF}, 1'b0, 1'b1, "R11 max divider");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule